// File: doc/BRIEF.md
# Receive Byte Queue with 16-bit Packing

This block is the receive-side buffer of a serial peripheral. A deserializer hands it one byte at a time. The block stores the bytes in a four-byte queue and gives them to the host through a 16-bit read port. The host may read with an 8-bit access, which returns one byte. It may instead read with a 16-bit access, which returns two bytes: the older byte in the low half and the newer byte in the high half. A byte that arrives while the queue is full is dropped, and a sticky overrun flag is raised.

The data-ready flag has two thresholds. At the half setting it needs two bytes, and at the quarter setting it needs one. Two configuration fields can be written only while the peripheral is disabled: the frame-length code (reset value 7, meaning 8-bit frames) and an odd-count hint for DMA. A frame tracker state machine is loaded with the transfer length when the peripheral is enabled. It has three states:
- `TRK_OFF`: the peripheral is disabled.
- `TRK_RECV`: frames are still expected.
- `TRK_LAST`: all frames have arrived.

The tracker moves between states as follows:
- `TRK_OFF`→`TRK_RECV` on an enable rise with a non-zero length.
- `TRK_OFF`→`TRK_LAST` on an enable rise with a zero length.
- `TRK_RECV`→`TRK_LAST` when the final frame completes.
- Any state goes to `TRK_OFF` when enable drops.

When frames are 8 bits or narrower, a frame is one byte. When frames are wider, a frame is two bytes. In `TRK_LAST` with the odd hint and receive DMA enabled, a lone last byte raises the ready flag even at the half threshold. A 16-bit read then returns that byte with a zero upper half.

Top module: `rxq_pack_buf`

## Requirements
- R1: After reset the queue is empty: `level` is 0, `rx_ready` is 0, `overrun` is 0, `rd_data` is 0, `cfg_len_q` is 7 and `cfg_odd_q` is 0.
- R2: With `thr_quarter`=0 and no release condition, `rx_ready` is 1 exactly when the queue holds two or more bytes.
- R3: With `thr_quarter`=1, `rx_ready` is 1 whenever the queue holds one or more bytes.
- R4: A read with `rd_wide`=1 removes two bytes when at least two are stored. One cycle later `rd_data[7:0]` holds the older byte and `rd_data[15:8]` holds the newer byte.
- R5: A read with `rd_wide`=0 removes one byte. One cycle later `rd_data` holds that byte in bits 7:0, with bits 15:8 zero.
- R6: A byte that arrives while four bytes are stored is discarded and sets `overrun`. `overrun` stays 1 until `overrun_clr` is pulsed.
- R7: `level` is coded as 0 for empty, 1 for one byte, 2 for two or three bytes, and 3 for four bytes.
- R8: A `cfg_wr` pulse updates `cfg_len_q` and `cfg_odd_q` only while `enable`=0. While `enable`=1 the pulse has no effect.
- R9: The frame count is loaded from `xfer_len` on the rising edge of `enable`. When `dma_rx_en`=1, `cfg_odd_q`=1 and `cfg_len_q`≤7, then once that many frames have arrived a single stored byte raises `rx_ready`. A 16-bit read then returns it as `{8'h00, byte}`.
- R10: If the odd hint is 0 or `dma_rx_en` is 0, a lone last byte does not raise `rx_ready` at the half threshold.
- R11: With `cfg_len_q`≥8 each frame takes two bytes, and the lone-byte release of R9 does not apply.
- R12: A read of an empty queue returns 0 and leaves `level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; its rise loads the frame count |
| xfer_len | input | 16 | Number of frames in the DMA block |
| dma_rx_en | input | 1 | Receive DMA enabled |
| thr_quarter | input | 1 | 1: one-byte threshold, 0: two-byte threshold |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len_in | input | 4 | Frame-length code (bits minus one) |
| cfg_odd_in | input | 1 | Odd frame-count hint to write |
| cfg_len_q | output | 4 | Current frame-length code |
| cfg_odd_q | output | 1 | Current odd hint |
| in_valid | input | 1 | A byte from the deserializer is present |
| in_byte | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe |
| rd_wide | input | 1 | 1: 16-bit access, 0: 8-bit access |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |
| rx_ready | output | 1 | Data-ready flag |
| level | output | 2 | Queue fill code |
| overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
A stimulus table drives the queue through several patterns:
- A fill to full, which shows each `level` code and the point at which the threshold flag changes.
- Packed reads, which show whether the byte order within the 16-bit word is right.
- A byte arriving in the same cycle as an 8-bit read, which checks that a simultaneous push and pop leave the count correct.
- Reads of an empty queue and a partly empty queue, which tell a zero return apart from stale data.

Directed sequences then cover several cases:
- A fill past full, which tells a dropped byte apart from a byte that overwrites stored data.
- Configuration writes with the peripheral enabled and disabled.
- A lone last byte under four settings, which separates the release condition from the even hint, from receive DMA being off, and from wide frames.

// File: rtl/rxq_pack_pkg.sv
package rxq_pack_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 4;
    localparam logic [LEN_W-1:0] LEN_RESET = 4'd7;

    typedef enum logic [1:0] {
        TRK_OFF  = 2'd0,
        TRK_RECV = 2'd1,
        TRK_LAST = 2'd2
    } trk_state_t;

    typedef enum logic [1:0] {
        LVL_EMPTY   = 2'd0,
        LVL_QUARTER = 2'd1,
        LVL_HALF    = 2'd2,
        LVL_FULL    = 2'd3
    } fill_lvl_t;
endpackage

// File: rtl/rxq_cfg_reg.sv
module rxq_cfg_reg
    import rxq_pack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr,
    input  logic [LEN_W-1:0] len_in,
    input  logic             odd_in,
    output logic [LEN_W-1:0] len_q,
    output logic             odd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_RESET;
            odd_q <= 1'b0;
        end else if (wr && !enable) begin
            len_q <= len_in;
            odd_q <= odd_in;
        end
    end

    // R8: configuration is frozen while the peripheral is enabled
    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(len_q) && $stable(odd_q)));
endmodule

// File: rtl/rxq_byte_fifo.sv
module rxq_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [W-1:0]       din,
    input  logic [1:0]         pop_n,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [W-1:0]       head0,
    output logic [W-1:0]       head1,
    output logic               drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          accept;

    assign accept = push && (count != CW'(DEPTH));
    assign drop   = push && (count == CW'(DEPTH));
    assign head0  = mem[rd_ptr];
    assign head1  = mem[PW'(rd_ptr + 1'b1)];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= PW'(wr_ptr + 1'b1);
            rd_ptr <= PW'(rd_ptr + PW'(pop_n));
            count  <= CW'(count + CW'(accept) - CW'(pop_n));
        end
    end

    // R7: occupancy never exceeds capacity
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6: a byte offered to a full queue with no read leaves the occupancy unchanged
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CW'(DEPTH) && pop_n == 2'd0) |=> $stable(count));
    // R4: never remove more bytes than are stored
    assert_pop_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count);
endmodule

// File: rtl/rxq_frame_trk.sv
module rxq_frame_trk
    import rxq_pack_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             byte_in,
    input  logic             wide_frames,
    output logic             all_rcvd
);
    trk_state_t       state, nxt;
    logic [CNT_W-1:0] left, left_nxt;
    logic             half, half_nxt;
    logic             en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TRK_OFF;
            left  <= '0;
            half  <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            left  <= left_nxt;
            half  <= half_nxt;
            en_q  <= enable;
        end
    end

    always_comb begin
        nxt      = state;
        left_nxt = left;
        half_nxt = half;
        if (!enable) begin
            nxt      = TRK_OFF;
            half_nxt = 1'b0;
        end else if (!en_q) begin
            left_nxt = xfer_len;
            half_nxt = 1'b0;
            nxt      = (xfer_len == '0) ? TRK_LAST : TRK_RECV;
        end else begin
            unique case (state)
                TRK_OFF:  nxt = TRK_OFF;
                TRK_RECV: begin
                    if (byte_in) begin
                        if (wide_frames && !half) begin
                            half_nxt = 1'b1;
                        end else begin
                            half_nxt = 1'b0;
                            left_nxt = left - 1'b1;
                            if (left == CNT_W'(1)) nxt = TRK_LAST;
                        end
                    end
                end
                TRK_LAST: nxt = TRK_LAST;
                default:  nxt = TRK_OFF;
            endcase
        end
    end

    always_comb begin
        all_rcvd = (state == TRK_LAST);
    end

    // R9: the final-frame state is only reachable with the peripheral enabled
    assert_last_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_LAST) |-> en_q);
    // R9: all frames counted when the final state is held
    assert_last_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_LAST) |-> (left == '0));
endmodule

// File: rtl/rxq_pack_buf.sv
module rxq_pack_buf
    import rxq_pack_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic              dma_rx_en,
    input  logic              thr_quarter,
    input  logic              cfg_wr,
    input  logic [LEN_W-1:0]  cfg_len_in,
    input  logic              cfg_odd_in,
    output logic [LEN_W-1:0]  cfg_len_q,
    output logic              cfg_odd_q,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              rd_en,
    input  logic              rd_wide,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic              rx_ready,
    output logic [1:0]        level,
    output logic              overrun,
    input  logic              overrun_clr
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0]     fcount;
    logic [BYTE_W-1:0] head0, head1;
    logic              drop;
    logic [1:0]        pop_n;
    logic              wide_frames;
    logic              all_rcvd;
    logic              release_lone;
    fill_lvl_t         lvl;

    assign wide_frames = (cfg_len_q > LEN_RESET);

    rxq_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .wr     (cfg_wr),
        .len_in (cfg_len_in),
        .odd_in (cfg_odd_in),
        .len_q  (cfg_len_q),
        .odd_q  (cfg_odd_q)
    );

    rxq_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .din   (in_byte),
        .pop_n (pop_n),
        .count (fcount),
        .head0 (head0),
        .head1 (head1),
        .drop  (drop)
    );

    rxq_frame_trk #(.CNT_W(CNT_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .xfer_len    (xfer_len),
        .byte_in     (in_valid),
        .wide_frames (wide_frames),
        .all_rcvd    (all_rcvd)
    );

    always_comb begin
        pop_n = 2'd0;
        if (rd_en && fcount != '0)
            pop_n = (rd_wide && fcount >= CW'(2)) ? 2'd2 : 2'd1;
    end

    always_comb begin
        if (fcount == '0)                lvl = LVL_EMPTY;
        else if (fcount == CW'(1))       lvl = LVL_QUARTER;
        else if (fcount == CW'(DEPTH))   lvl = LVL_FULL;
        else                             lvl = LVL_HALF;
    end
    assign level = lvl;

    assign release_lone = dma_rx_en && cfg_odd_q && !wide_frames &&
                          all_rcvd && (fcount == CW'(1));
    assign rx_ready = (thr_quarter ? (fcount >= CW'(1)) : (fcount >= CW'(2)))
                      || release_lone;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= drop || (overrun && !overrun_clr);
            if (rd_en)
                rd_data <= {(pop_n == 2'd2) ? head1 : {BYTE_W{1'b0}},
                            (pop_n != 2'd0) ? head0 : {BYTE_W{1'b0}}};
        end
    end

    // R6: overrun holds until cleared
    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !overrun_clr) |=> overrun);
    // R3: an empty queue never signals ready
    assert_empty_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'd0) |-> !rx_ready);
    // R5: a narrow read leaves the upper half zero
    assert_narrow_high_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_wide) |=> (rd_data[15:8] == 8'h00));
    // R12: reading an empty queue returns zero
    assert_empty_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == 2'd0 && !in_valid) |=> (rd_data == 16'h0000));
endmodule

// File: tb/rxq_pack_buf_bench.sv
module rxq_pack_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] xfer_len = 16'd0;
    logic        dma_rx_en = 1'b0;
    logic        thr_quarter = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_len_in = 4'd0;
    logic        cfg_odd_in = 1'b0;
    logic [3:0]  cfg_len_q;
    logic        cfg_odd_q;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        rd_en = 1'b0;
    logic        rd_wide = 1'b0;
    logic [15:0] rd_data;
    logic        rx_ready;
    logic [1:0]  level;
    logic        overrun;
    logic        overrun_clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rxq_pack_buf u_rxq_pack_buf (
        .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_len(xfer_len),
        .dma_rx_en(dma_rx_en), .thr_quarter(thr_quarter), .cfg_wr(cfg_wr),
        .cfg_len_in(cfg_len_in), .cfg_odd_in(cfg_odd_in), .cfg_len_q(cfg_len_q),
        .cfg_odd_q(cfg_odd_q), .in_valid(in_valid), .in_byte(in_byte),
        .rd_en(rd_en), .rd_wide(rd_wide), .rd_data(rd_data), .rx_ready(rx_ready),
        .level(level), .overrun(overrun), .overrun_clr(overrun_clr)
    );

    // push, byte, rd, wide, exp_ready, exp_level, chk_rd, exp_rd
    localparam int NV = 10;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0000},
        {1'b1, 8'hB2, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 16'h0000},
        {1'b1, 8'hC3, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 16'h0000},
        {1'b1, 8'hD4, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 16'h0000},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 16'hB2A1},
        {1'b1, 8'hE5, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 16'h00C3},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 16'hE5D4},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 16'h0000},
        {1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 16'h0000},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 16'h005A}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        in_valid = 1'b1; in_byte = b;
        tick();
        in_valid = 1'b0;
    endtask

    task automatic rd(input logic wide);
        rd_en = 1'b1; rd_wide = wide;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic cfg(input logic [3:0] len, input logic odd);
        cfg_wr = 1'b1; cfg_len_in = len; cfg_odd_in = odd;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic restart(input logic [15:0] n);
        xfer_len = n; enable = 1'b1;
        tick();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 level", 16'(level), 16'd0);
        chk("R1 ready", 16'(rx_ready), 16'd0);
        chk("R1 overrun", 16'(overrun), 16'd0);
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 len", 16'(cfg_len_q), 16'd7);
        chk("R1 odd", 16'(cfg_odd_q), 16'd0);

        restart(16'd100);
        // table walk: R2 ready, R7 level, R4/R5/R12 read data
        for (int i = 0; i < NV; i++) begin
            in_valid = VEC[i][30]; in_byte = VEC[i][29:22];
            rd_en = VEC[i][21]; rd_wide = VEC[i][20];
            tick();
            in_valid = 1'b0; rd_en = 1'b0;
            chk("R2 ready", 16'(rx_ready), 16'(VEC[i][19]));
            chk("R7 level", 16'(level), 16'(VEC[i][18:17]));
            if (VEC[i][16]) chk("R4 R5 R12 rd_data", rd_data, VEC[i][15:0]);
        end

        // R3 quarter threshold
        thr_quarter = 1'b1;
        push(8'h81);
        chk("R3 ready quarter", 16'(rx_ready), 16'd1);
        thr_quarter = 1'b0; #1;
        chk("R2 ready half one byte", 16'(rx_ready), 16'd0);
        rd(1'b0);
        chk("R5 narrow read", rd_data, 16'h0081);

        // R6 overrun
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        push(8'h55);
        chk("R6 overrun set", 16'(overrun), 16'd1);
        chk("R6 level full", 16'(level), 16'd3);
        tick();
        chk("R6 overrun sticky", 16'(overrun), 16'd1);
        rd(1'b1);
        chk("R6 first pair", rd_data, 16'h2211);
        rd(1'b1);
        chk("R6 dropped byte absent", rd_data, 16'h4433);
        chk("R6 overrun held", 16'(overrun), 16'd1);
        overrun_clr = 1'b1; tick(); overrun_clr = 1'b0;
        chk("R6 overrun cleared", 16'(overrun), 16'd0);

        // R8 configuration lock
        cfg(4'd3, 1'b1);
        chk("R8 len locked", 16'(cfg_len_q), 16'd7);
        chk("R8 odd locked", 16'(cfg_odd_q), 16'd0);
        enable = 1'b0; tick();
        cfg(4'd3, 1'b1);
        chk("R8 len written", 16'(cfg_len_q), 16'd3);
        chk("R8 odd written", 16'(cfg_odd_q), 16'd1);

        // R9 lone final byte release
        cfg(4'd7, 1'b1);
        dma_rx_en = 1'b1;
        restart(16'd3);
        push(8'h61); push(8'h62);
        rd(1'b1);
        chk("R9 packed pair", rd_data, 16'h6261);
        push(8'h63);
        chk("R9 lone byte ready", 16'(rx_ready), 16'd1);
        rd(1'b1);
        chk("R9 lone byte read", rd_data, 16'h0063);
        chk("R9 ready after read", 16'(rx_ready), 16'd0);

        // R10 even hint
        enable = 1'b0; tick();
        cfg(4'd7, 1'b0);
        restart(16'd1);
        push(8'h91);
        chk("R10 even hint no ready", 16'(rx_ready), 16'd0);
        rd(1'b0);
        chk("R10 drain", rd_data, 16'h0091);
        // R10 DMA off
        enable = 1'b0; tick();
        cfg(4'd7, 1'b1);
        dma_rx_en = 1'b0;
        restart(16'd1);
        push(8'h92);
        chk("R10 dma off no ready", 16'(rx_ready), 16'd0);
        rd(1'b0);

        // R11 wide frames
        enable = 1'b0; tick();
        cfg(4'd11, 1'b1);
        dma_rx_en = 1'b1;
        restart(16'd1);
        push(8'h71); push(8'h72);
        chk("R11 two bytes ready", 16'(rx_ready), 16'd1);
        rd(1'b0);
        chk("R11 narrow read", rd_data, 16'h0071);
        chk("R11 no lone release", 16'(rx_ready), 16'd0);
        chk("R11 level", 16'(level), 16'd1);
        rd(1'b0);
        rd(1'b1);
        chk("R12 empty wide read", rd_data, 16'h0000);
        chk("R12 level empty", 16'(level), 16'd0);

        finish_run();
    end
endmodule